// File: doc/BRIEF.md
# Periodic Program Restart Timer

This block decides when a small always-on coprocessor program is started again. Software loads up to five sleep periods and then issues a run command with a start address. The block answers at once with a restart strobe at that address. Each time the program halts, the block spends a fixed number of cycles preparing for sleep. It then counts up to the selected period and spends a fixed number of cycles waking. Finally it strobes a restart at the saved start address.

The program picks which of the five periods applies by issuing a select instruction with an index. A halt leaves the timer armed, so the program keeps being restarted at a regular interval. An end command disarms the timer. The program that is running carries on until it halts, and no restart follows that halt. A later run command arms the timer again.

Top module: `rerun_timer`

## Requirements
- R1: After a synchronous reset, `restart_pulse` and `busy` are 0, the timer is disarmed, all periods are 0 and period index 0 is selected.
- R2: A write with `cfg_we` high and `cfg_addr` 0 to 4 stores `cfg_wdata` into that period register. Address 5 sets the timer enable from `cfg_wdata[0]`. Addresses 6 and 7 change nothing.
- R3: A run command arms the timer and saves `run_addr`. One cycle later `restart_pulse` is high for exactly one cycle, with `restart_addr` equal to `run_addr` and `busy` high.
- R4: A halt sampled while the program runs with the timer armed produces one restart pulse exactly 2 + P + 1 + 2 = P + 5 clock edges later, where P is the selected period. The restart address is the saved start address. The 32-bit count starts again from zero on every halt.
- R5: A selected period of 0 restarts 5 edges after the halt, immediately after the two wake-up cycles.
- R6: A select instruction (`sel_valid` high) whose index in `sel_idx[3:0]` is 0 to 4 chooses the period register used by every later wait.
- R7: A select index of 5 to 15 is ignored, and the previous selection stays in force.
- R8: Because a halt keeps the timer armed, every halt of a restarted program leads to a further restart.
- R9: An end command disarms the timer. `busy` stays high until the next halt, drops to 0 on the edge that samples that halt, and no restart follows until a new run command.
- R10: Writing 0 to the enable while a restart is pending cancels it: `busy` drops to 0 and no restart pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (3) | 0-4 period register, 5 enable, others ignored |
| cfg_wdata | input | PERIOD_W (32) | Write data |
| run_req | input | 1 | Run command: arm, save address, restart now |
| run_addr | input | ADDR_W (11) | Program start address for the run command |
| core_halt | input | 1 | Program halted (one-cycle pulse) |
| sel_valid | input | 1 | Period-select instruction executed |
| sel_idx | input | SEL_IN_W (4) | Period index carried by the select instruction |
| end_cmd | input | 1 | End command: disarm the timer |
| restart_pulse | output | 1 | One-cycle program restart strobe |
| restart_addr | output | ADDR_W (11) | Address to restart from, valid with the strobe |
| busy | output | 1 | Program running or a restart pending |

## Verification
The assertions assume that `core_halt` arrives only as a single-cycle pulse while a restarted program is running. They also assume that `run_req` is never held across consecutive cycles. The bench therefore drives each command as a one-cycle pulse, issues halts only after it has seen a restart, and changes periods and selections only while the program is running. Select indices are drawn from the full 4-bit range so that ignored values occur often. Periods are kept small so that each wait finishes quickly.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_PREP  = 3'd2,
    ST_COUNT = 3'd3,
    ST_WAKE  = 3'd4
  } rrt_state_e;
endpackage

// File: rtl/rrt_period_bank.sv
module rrt_period_bank #(
  parameter int NUM_PERIODS = 5,
  parameter int PERIOD_W    = 32,
  parameter int CFG_AW      = 3,
  parameter int SEL_IN_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [PERIOD_W-1:0] cfg_wdata,
  input  logic                sel_valid,
  input  logic [SEL_IN_W-1:0] sel_idx,
  output logic [PERIOD_W-1:0] sel_period,
  output logic                en_we,
  output logic                en_val
);
  localparam int SEL_W = (NUM_PERIODS > 1) ? $clog2(NUM_PERIODS) : 1;

  logic [PERIOD_W-1:0] per_q [NUM_PERIODS];
  logic [SEL_W-1:0]    sel_q;
  logic                sel_ok;

  // one register per period slot, written by its own address decode
  generate
    for (genvar i = 0; i < NUM_PERIODS; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst)
          per_q[i] <= '0;
        else if (cfg_we && cfg_addr == CFG_AW'(i))
          per_q[i] <= cfg_wdata;
      end
    end
  endgenerate

  assign sel_ok = sel_valid && (int'(sel_idx) < NUM_PERIODS);

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= '0;
    else if (sel_ok)
      sel_q <= sel_idx[SEL_W-1:0];
  end

  assign sel_period = per_q[sel_q];
  assign en_we      = cfg_we && (cfg_addr == CFG_AW'(NUM_PERIODS));
  assign en_val     = cfg_wdata[0];

  // R7: an out-of-range select leaves the selection untouched
  assert_sel_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && int'(sel_idx) >= NUM_PERIODS) |=> $stable(sel_q));

  // R6: the selection always names an existing period register
  assert_sel_range_R6: assert property (@(posedge clk) disable iff (rst)
    int'(sel_q) < NUM_PERIODS);
endmodule

// File: rtl/rrt_sleep_counter.sv
module rrt_sleep_counter #(
  parameter int PERIOD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnt_en,
  input  logic [PERIOD_W-1:0] period,
  output logic [PERIOD_W-1:0] count,
  output logic                match
);
  // counts only while the sequencer is in its counting state; held at 0 otherwise
  always_ff @(posedge clk) begin
    if (rst || !cnt_en)
      count <= '0;
    else
      count <= count + 1'b1;
  end

  assign match = cnt_en && (count == period);
endmodule

// File: rtl/rrt_sequencer.sv
module rrt_sequencer
  import rrt_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PREP_CYC = 2,
  parameter int WAKE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_req,
  input  logic [ADDR_W-1:0] run_addr,
  input  logic              halt,
  input  logic              end_cmd,
  input  logic              en_we,
  input  logic              en_val,
  input  logic              match,
  output logic              cnt_en,
  output rrt_state_e        state,
  output logic              restart_pulse,
  output logic [ADDR_W-1:0] restart_addr,
  output logic              busy
);
  localparam int PH_MAX = (PREP_CYC > WAKE_CYC) ? PREP_CYC : WAKE_CYC;
  localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;

  rrt_state_e        st_q, st_nxt;
  logic [PH_W-1:0]   ph_q, ph_nxt;
  logic              en_q, en_nxt;
  logic [ADDR_W-1:0] start_q;
  logic              fire;

  always_comb begin
    st_nxt = st_q;
    ph_nxt = ph_q;
    en_nxt = en_q;
    fire   = 1'b0;
    if (en_we)
      en_nxt = en_val;
    if (end_cmd)
      en_nxt = 1'b0;
    unique case (st_q)
      ST_IDLE: ;
      ST_RUN: begin
        if (halt) begin
          st_nxt = en_nxt ? ST_PREP : ST_IDLE;
          ph_nxt = '0;
        end
      end
      ST_PREP: begin
        if (!en_nxt)
          st_nxt = ST_IDLE;
        else if (ph_q == PH_W'(PREP_CYC - 1)) begin
          st_nxt = ST_COUNT;
          ph_nxt = '0;
        end else
          ph_nxt = ph_q + 1'b1;
      end
      ST_COUNT: begin
        if (!en_nxt)
          st_nxt = ST_IDLE;
        else if (match) begin
          st_nxt = ST_WAKE;
          ph_nxt = '0;
        end
      end
      ST_WAKE: begin
        if (!en_nxt)
          st_nxt = ST_IDLE;
        else if (ph_q == PH_W'(WAKE_CYC - 1)) begin
          st_nxt = ST_RUN;
          fire   = 1'b1;
        end else
          ph_nxt = ph_q + 1'b1;
      end
      default: st_nxt = ST_IDLE;
    endcase
    // a run command overrides everything: arm and restart immediately
    if (run_req) begin
      en_nxt = 1'b1;
      st_nxt = ST_RUN;
      ph_nxt = '0;
      fire   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= ST_IDLE;
      ph_q          <= '0;
      en_q          <= 1'b0;
      start_q       <= '0;
      restart_pulse <= 1'b0;
      restart_addr  <= '0;
      busy          <= 1'b0;
    end else begin
      st_q          <= st_nxt;
      ph_q          <= ph_nxt;
      en_q          <= en_nxt;
      restart_pulse <= fire;
      busy          <= (st_nxt != ST_IDLE);
      if (run_req)
        start_q <= run_addr;
      if (fire)
        restart_addr <= run_req ? run_addr : start_q;
    end
  end

  assign cnt_en = (st_q == ST_COUNT);
  assign state  = st_q;

  // R4: the wake phase is entered only from a counting cycle that matched
  assert_wake_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAKE && $past(st_q) != ST_WAKE) |-> ($past(st_q) == ST_COUNT && $past(match)));

  // R9: a timed restart needs the timer to have been armed
  assert_no_fire_disarmed_R9: assert property (@(posedge clk) disable iff (rst)
    (restart_pulse && !$past(run_req)) |-> $past(en_q));
endmodule

// File: rtl/rerun_timer.sv
module rerun_timer
  import rrt_pkg::*;
#(
  parameter int NUM_PERIODS = 5,
  parameter int PERIOD_W    = 32,
  parameter int ADDR_W      = 11,
  parameter int SEL_IN_W    = 4,
  parameter int PREP_CYC    = 2,
  parameter int WAKE_CYC    = 2,
  parameter int CFG_AW      = $clog2(NUM_PERIODS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [PERIOD_W-1:0] cfg_wdata,
  input  logic                run_req,
  input  logic [ADDR_W-1:0]   run_addr,
  input  logic                core_halt,
  input  logic                sel_valid,
  input  logic [SEL_IN_W-1:0] sel_idx,
  input  logic                end_cmd,
  output logic                restart_pulse,
  output logic [ADDR_W-1:0]   restart_addr,
  output logic                busy
);
  logic [PERIOD_W-1:0] sel_period;
  logic [PERIOD_W-1:0] count;
  logic                en_we, en_val, cnt_en, match;
  rrt_state_e          state;

  rrt_period_bank #(
    .NUM_PERIODS(NUM_PERIODS), .PERIOD_W(PERIOD_W),
    .CFG_AW(CFG_AW), .SEL_IN_W(SEL_IN_W)
  ) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sel_valid(sel_valid), .sel_idx(sel_idx),
    .sel_period(sel_period), .en_we(en_we), .en_val(en_val)
  );

  rrt_sleep_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .period(sel_period),
    .count(count), .match(match)
  );

  rrt_sequencer #(
    .ADDR_W(ADDR_W), .PREP_CYC(PREP_CYC), .WAKE_CYC(WAKE_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .run_req(run_req), .run_addr(run_addr),
    .halt(core_halt), .end_cmd(end_cmd), .en_we(en_we), .en_val(en_val),
    .match(match), .cnt_en(cnt_en), .state(state),
    .restart_pulse(restart_pulse), .restart_addr(restart_addr), .busy(busy)
  );

  // R3: every restart strobe comes with busy asserted
  assert_pulse_busy_R3: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |-> busy);

  // R4: each wait starts counting from zero
  assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_COUNT) |-> (count == '0));
endmodule

// File: tb/test_rerun_timer.sv
module test_rerun_timer;
  localparam int NP = 5, PW = 32, AW = 11, SW = 4, PREP = 2, WAKE = 2;
  localparam int CAW = $clog2(NP + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [CAW-1:0] cfg_addr = '0;
  logic [PW-1:0] cfg_wdata = '0;
  logic run_req = 1'b0;
  logic [AW-1:0] run_addr = '0;
  logic core_halt = 1'b0, sel_valid = 1'b0, end_cmd = 1'b0;
  logic [SW-1:0] sel_idx = '0;
  logic restart_pulse, busy;
  logic [AW-1:0] restart_addr;

  int n_chk = 0, n_bad = 0;
  logic [PW-1:0] m_per [NP];
  int m_sel = 0;
  logic [AW-1:0] m_addr = '0;

  always #2 clk = ~clk;

  rerun_timer #(.NUM_PERIODS(NP), .PERIOD_W(PW), .ADDR_W(AW), .SEL_IN_W(SW),
                .PREP_CYC(PREP), .WAKE_CYC(WAKE)) i_rerun_timer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .run_req(run_req), .run_addr(run_addr), .core_halt(core_halt),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .end_cmd(end_cmd),
    .restart_pulse(restart_pulse), .restart_addr(restart_addr), .busy(busy));

  function automatic int exp_lat(int p);
    return PREP + WAKE + p + 1;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_cfg(int a, logic [PW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a[CAW-1:0]; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
    if (a < NP) m_per[a] = d;
  endtask

  task automatic do_sel(int i);
    sel_valid = 1'b1; sel_idx = i[SW-1:0];
    step();
    sel_valid = 1'b0;
    if (i < NP) m_sel = i;
  endtask

  task automatic do_run(logic [AW-1:0] a, string req);
    run_req = 1'b1; run_addr = a;
    step();
    run_req = 1'b0; m_addr = a;
    check(restart_pulse == 1'b1, req, "run restart pulse", restart_pulse, 1);
    check(restart_addr == a, req, "run restart address", restart_addr, a);
    check(busy == 1'b1, req, "busy after run", busy, 1);
    step();
    check(restart_pulse == 1'b0, req, "pulse lasts one cycle", restart_pulse, 0);
  endtask

  task automatic halt_expect(string req);
    int n, e;
    e = exp_lat(int'(m_per[m_sel]));
    core_halt = 1'b1;
    step();
    core_halt = 1'b0;
    n = 0;
    do begin
      step();
      n++;
    end while (!restart_pulse && n < 200);
    check(n == e, req, "halt-to-restart cycles", n, e);
    check(restart_addr == m_addr, req, "restart address", restart_addr, m_addr);
  endtask

  task automatic expect_silent(string req, int cycles);
    bit seen;
    seen = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      step();
      if (restart_pulse) seen = 1'b1;
    end
    check(!seen, req, "no restart pulse", seen, 0);
    check(busy == 1'b0, req, "busy low while stopped", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) m_per[i] = '0;
    void'($urandom(32'd2024));
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1: reset state
    check(restart_pulse == 1'b0, "R1", "pulse after reset", restart_pulse, 0);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    expect_silent("R1", 10);

    // R2: program periods
    wr_cfg(0, 12); wr_cfg(1, 3); wr_cfg(2, 0); wr_cfg(3, 7); wr_cfg(4, 20);
    do_run(11'h123, "R3");
    halt_expect("R1");           // default index 0 after reset
    do_sel(2);
    halt_expect("R5");           // period 0
    do_sel(1);
    halt_expect("R6");
    do_sel(4);
    halt_expect("R6");
    do_sel(5); do_sel(9); do_sel(15);
    halt_expect("R7");           // still index 4
    wr_cfg(6, 0); wr_cfg(7, 0);
    halt_expect("R2");           // stray addresses leave periods and enable alone
    for (int k = 0; k < 3; k++) halt_expect("R8");

    // R9: end command
    end_cmd = 1'b1;
    step();
    end_cmd = 1'b0;
    repeat (5) step();
    check(busy == 1'b1, "R9", "program still running after end", busy, 1);
    core_halt = 1'b1;
    step();
    core_halt = 1'b0;
    check(busy == 1'b0, "R9", "busy after halt when disarmed", busy, 0);
    expect_silent("R9", 60);
    do_run(11'h7FF, "R9");
    halt_expect("R9");

    // R10: disarm during a pending wait
    do_sel(4);
    core_halt = 1'b1;
    step();
    core_halt = 1'b0;
    repeat (3) step();
    wr_cfg(5, 0);
    check(busy == 1'b0, "R10", "busy after disarm write", busy, 0);
    expect_silent("R10", 60);
    do_run(11'h055, "R10");
    halt_expect("R10");

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int r;
      r = int'($urandom_range(0, 4));
      case (r)
        0: do_sel(int'($urandom_range(0, 15)));
        1: wr_cfg(int'($urandom_range(0, NP - 1)), PW'($urandom_range(0, 40)));
        2: wr_cfg(int'($urandom_range(6, 7)), PW'($urandom_range(0, 1)));
        3: do_run(AW'($urandom_range(0, 2047)), "R3");
        default: ;
      endcase
      halt_expect("R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule